// File: doc/BRIEF.md
# Packed FP8-to-FP32 Widening Converter

This block turns one 64-bit word carrying eight packed 8-bit floating-point numbers into eight IEEE-754 single-precision numbers in one pass. A 3-bit code, given with each word, picks how all eight bytes are read. The block handles five 8-bit encodings. They differ in the split between exponent and fraction bits, in the exponent bias, and in how infinities, NaNs and negative zero are encoded. Every 8-bit value fits exactly in single precision, so no rounding takes place. Subnormal inputs are normalized and come out as normal single-precision values.

Words are accepted through a valid/ready handshake. The eight converted lanes are held in one output register that has its own valid flag, and a downstream ready releases them. While the register holds a result that has not been taken, the block refuses new input. This lets a consumer stall the converter without any data being lost.

Top module: `fp8w_top`

## Requirements
- R1: A word is accepted on a rising clock edge where in_valid and in_ready are both high. out_valid is high in the cycle right after that edge and stays low if nothing was accepted.
- R2: While out_valid is high and out_ready is low, in_ready is low and out_lanes holds its value.
- R3: After reset, out_valid is low and in_ready is high.
- R4: Byte i of in_word (bits 8i+7..8i) converts to bits 32i+31..32i of out_lanes, for every lane i.
- R5: Format codes and biases: 0 = E5M2 (bias 15), 1 = E4M3 finite (bias 7), 2 = E5M2 unsigned-zero (bias 16), 3 = E4M3 unsigned-zero (bias 8), 4 = E4M3 unsigned-zero with bias 11. A normal input converts exactly, for example 0x3C in code 0 gives 0x3F800000.
- R6: A subnormal input (exponent field zero, fraction non-zero) gives the exact normalized single-precision value, for example 0x01 in code 3 gives 0x3A800000 (2^-10).
- R7: A zero input gives single-precision zero with the input's sign, for example 0x80 in code 0 or 1 gives 0x80000000.
- R8: In code 0, an all-ones exponent field with zero fraction gives a signed infinity (0x7F800000 or 0xFF800000). An all-ones exponent field with a non-zero fraction gives 0x7FC00000.
- R9: In code 1, only 0x7F and 0xFF are NaN and give 0x7FC00000. Every other byte is finite, for example 0x7E gives 448.0 (0x43E00000).
- R10: In codes 2, 3 and 4, byte 0x80 is the only NaN and gives 0x7FC00000. 0x00 gives +0.
- R11: Codes 5, 6 and 7 make every lane 0x7FC00000, whatever the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word and format code are valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_fmt | input | 3 | Format code for all lanes of the word |
| in_word | input | 64 | Eight packed 8-bit values, lane 0 in the low byte |
| out_valid | output | 1 | out_lanes holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_lanes | output | 256 | Eight single-precision results, lane 0 in the low word |

## Verification
The bench builds the block with its default parameters: eight lanes of 8-bit inputs and 32-bit outputs, and a 3-bit format code. The 3-bit code makes the three undefined codes reachable next to the five defined ones. Eight lanes let one word with eight different bytes show the lane mapping and several special-value rules at the same time. The vector table covers each encoding at its bias point, its smallest subnormal, its largest finite value and its NaN and infinity patterns. A stalled consumer is then used to test the hold and refuse behaviour of the output register.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

   localparam int unsigned FMT_W = 3;
   localparam logic [31:0] CANON_QNAN = 32'h7FC0_0000;

   typedef enum logic [FMT_W-1:0] {
      FMT_E5M2_IEEE  = 3'd0,
      FMT_E4M3_FIN   = 3'd1,
      FMT_E5M2_UZ    = 3'd2,
      FMT_E4M3_UZ    = 3'd3,
      FMT_E4M3_B11UZ = 3'd4
   } fp8_fmt_e;

   // Decode rules for one encoding
   typedef struct packed {
      logic       known;      // code names a defined encoding
      logic       wide_exp;   // 5 exponent bits (else 4)
      logic       has_inf;    // all-ones exponent means inf / NaN
      logic       nan_ones;   // only all-ones magnitude is NaN
      logic       uz;         // 0x80 is the single NaN
      logic [4:0] bias;
   } fmt_info_t;

   function automatic fmt_info_t fmt_lookup(logic [FMT_W-1:0] code);
      fmt_info_t r;
      r = '0;
      case (code)
         FMT_E5M2_IEEE:  r = '{known:1'b1, wide_exp:1'b1, has_inf:1'b1, nan_ones:1'b0, uz:1'b0, bias:5'd15};
         FMT_E4M3_FIN:   r = '{known:1'b1, wide_exp:1'b0, has_inf:1'b0, nan_ones:1'b1, uz:1'b0, bias:5'd7};
         FMT_E5M2_UZ:    r = '{known:1'b1, wide_exp:1'b1, has_inf:1'b0, nan_ones:1'b0, uz:1'b1, bias:5'd16};
         FMT_E4M3_UZ:    r = '{known:1'b1, wide_exp:1'b0, has_inf:1'b0, nan_ones:1'b0, uz:1'b1, bias:5'd8};
         FMT_E4M3_B11UZ: r = '{known:1'b1, wide_exp:1'b0, has_inf:1'b0, nan_ones:1'b0, uz:1'b1, bias:5'd11};
         default:        r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fp8w_msb.sv
// Index of the highest set bit of a small vector.
module fp8w_msb #(
   parameter int unsigned W  = 3,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < int'(W); i++) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/fp8w_lane.sv
// Widens one 8-bit value to single precision under a given encoding.
module fp8w_lane
   import fp8w_pkg::*;
(
   input  fmt_info_t   info,
   input  logic [7:0]  code,
   output logic [31:0] wide
);
   logic       sgn;
   logic [4:0] efield;
   logic [2:0] frac3;   // fraction, left aligned to 3 bits
   logic [4:0] emax;
   logic [1:0] lead;
   logic [2:0] sub_frac;
   logic [7:0] norm_exp;
   logic [7:0] sub_exp;

   assign sgn    = code[7];
   assign efield = info.wide_exp ? code[6:2] : {1'b0, code[6:3]};
   assign frac3  = info.wide_exp ? {code[1:0], 1'b0} : code[2:0];
   assign emax   = info.wide_exp ? 5'd31 : 5'd15;

   fp8w_msb #(.W(3)) u_msb (
      .vec (frac3),
      .idx (lead)
   );

   // value = frac3 * 2^(1-bias-3); leading one at bit 'lead'
   assign sub_frac = frac3 << (2'd3 - lead);
   assign sub_exp  = 8'd125 + 8'(lead) - 8'(info.bias);
   assign norm_exp = 8'(efield) + 8'd127 - 8'(info.bias);

   always_comb begin
      if (!info.known) begin
         wide = CANON_QNAN;
      end else if (info.uz && code == 8'h80) begin
         wide = CANON_QNAN;
      end else if (info.has_inf && efield == emax) begin
         wide = (frac3 == 3'd0) ? {sgn, 8'hFF, 23'd0} : CANON_QNAN;
      end else if (info.nan_ones && code[6:0] == 7'h7F) begin
         wide = CANON_QNAN;
      end else if (efield == 5'd0) begin
         if (frac3 == 3'd0) wide = {sgn, 31'd0};
         else               wide = {sgn, sub_exp, sub_frac, 20'd0};
      end else begin
         wide = {sgn, norm_exp, frac3, 20'd0};
      end
   end
endmodule

// File: rtl/fp8w_top.sv
module fp8w_top
   import fp8w_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 8,
   parameter int unsigned WIDE_W = 32,
   localparam int unsigned IN_W  = LANES * ELEM_W,
   localparam int unsigned OUT_W = LANES * WIDE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [FMT_W-1:0]   in_fmt,
   input  logic [IN_W-1:0]    in_word,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OUT_W-1:0]   out_lanes
);
   if (ELEM_W != 8) begin : g_bad_elem
      $error("fp8w_top: ELEM_W must be 8");
   end
   if (WIDE_W != 32) begin : g_bad_wide
      $error("fp8w_top: WIDE_W must be 32");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("fp8w_top: LANES must be at least 1");
   end

   fmt_info_t          info;
   logic [OUT_W-1:0]   wide_d;
   logic               accept;

   assign info = fmt_lookup(in_fmt);

   for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      fp8w_lane u_lane (
         .info (info),
         .code (in_word[g*ELEM_W +: ELEM_W]),
         .wide (wide_d[g*WIDE_W +: WIDE_W])
      );
   end

   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lanes <= '0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_lanes <= wide_d;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/fp8w_chk.sv
module fp8w_chk
   import fp8w_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ELEM_W = 8,
   parameter int unsigned WIDE_W = 32,
   localparam int unsigned IN_W  = LANES * ELEM_W,
   localparam int unsigned OUT_W = LANES * WIDE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [FMT_W-1:0] in_fmt,
   input logic [IN_W-1:0]  in_word,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_lanes
);
   a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   a_r1_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   a_r2_hold_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes)));

   a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   a_r3_reset_clear: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   a_r11_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_fmt > 3'd4) |=> (out_lanes == {LANES{CANON_QNAN}}));

   for (genvar g = 0; g < int'(LANES); g++) begin : g_uz
      a_r10_uz_nan: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && in_fmt >= 3'd2 && in_fmt <= 3'd4 &&
          in_word[g*ELEM_W +: ELEM_W] == 8'h80)
         |=> (out_lanes[g*WIDE_W +: WIDE_W] == CANON_QNAN));
   end
endmodule

bind fp8w_top fp8w_chk #(.LANES(LANES), .ELEM_W(ELEM_W), .WIDE_W(WIDE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_fmt    (in_fmt),
   .in_word   (in_word),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_lanes (out_lanes)
);

// File: tb/tb_fp8w_top.sv
module tb_fp8w_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [2:0]   in_fmt = 3'd0;
   logic [63:0]  in_word = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [255:0] out_lanes;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   fp8w_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_fmt    (in_fmt),
      .in_word   (in_word),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_lanes (out_lanes)
   );

   // {format, byte, expected single-precision result}
   localparam int NV = 34;
   localparam logic [42:0] VEC [NV] = '{
      {3'd0, 8'h3C, 32'h3F80_0000},   // R5
      {3'd0, 8'h7B, 32'h4760_0000},   // R5 max finite
      {3'd0, 8'h01, 32'h3780_0000},   // R6
      {3'd0, 8'h03, 32'h3840_0000},   // R6
      {3'd0, 8'h00, 32'h0000_0000},   // R7
      {3'd0, 8'h80, 32'h8000_0000},   // R7
      {3'd0, 8'h7C, 32'h7F80_0000},   // R8
      {3'd0, 8'hFC, 32'hFF80_0000},   // R8
      {3'd0, 8'h7D, 32'h7FC0_0000},   // R8
      {3'd0, 8'hFF, 32'h7FC0_0000},   // R8
      {3'd1, 8'h38, 32'h3F80_0000},   // R5
      {3'd1, 8'hC0, 32'hC000_0000},   // R5
      {3'd1, 8'h7E, 32'h43E0_0000},   // R9
      {3'd1, 8'h78, 32'h4380_0000},   // R9
      {3'd1, 8'h7F, 32'h7FC0_0000},   // R9
      {3'd1, 8'hFF, 32'h7FC0_0000},   // R9
      {3'd1, 8'h01, 32'h3B00_0000},   // R6
      {3'd1, 8'h80, 32'h8000_0000},   // R7
      {3'd2, 8'h40, 32'h3F80_0000},   // R5
      {3'd2, 8'hFF, 32'hC760_0000},   // R5
      {3'd2, 8'h01, 32'h3700_0000},   // R6
      {3'd2, 8'h80, 32'h7FC0_0000},   // R10
      {3'd2, 8'h00, 32'h0000_0000},   // R10
      {3'd3, 8'h40, 32'h3F80_0000},   // R5
      {3'd3, 8'h7F, 32'h4370_0000},   // R5
      {3'd3, 8'h01, 32'h3A80_0000},   // R6
      {3'd3, 8'h06, 32'h3BC0_0000},   // R6
      {3'd3, 8'h80, 32'h7FC0_0000},   // R10
      {3'd4, 8'h58, 32'h3F80_0000},   // R5
      {3'd4, 8'hFF, 32'hC1F0_0000},   // R5
      {3'd4, 8'h01, 32'h3900_0000},   // R6
      {3'd4, 8'h80, 32'h7FC0_0000},   // R10
      {3'd5, 8'h38, 32'h7FC0_0000},   // R11
      {3'd7, 8'h00, 32'h7FC0_0000}    // R11
   };

   task automatic check(input bit ok, input string req, input logic [255:0] act,
                        input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Called at a falling edge; returns at the falling edge after acceptance.
   task automatic send(input logic [2:0] f, input logic [63:0] w);
      in_fmt   = f;
      in_word  = w;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [255:0] held;
      repeat (3) @(negedge clk);
      // R3 reset state
      check(out_valid == 1'b0, "R3 out_valid in reset", 256'(out_valid), 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, "R3 after reset",
            256'({out_valid, in_ready}), 256'b01);

      // Table walk: every lane gets the same byte
      for (int k = 0; k < NV; k++) begin
         logic [2:0]  f;
         logic [7:0]  b;
         logic [31:0] e;
         {f, b, e} = VEC[k];
         check(out_valid == 1'b0, "R1 idle before accept", 256'(out_valid), 256'd0);
         send(f, {8{b}});
         check(out_valid == 1'b1, "R1 valid one cycle after accept", 256'(out_valid), 256'd1);
         check(out_lanes == {8{e}}, $sformatf("R5-table fmt %0d byte %h (vector %0d)", f, b, k),
               out_lanes, {8{e}});
         @(negedge clk);
         check(out_valid == 1'b0, "R1 valid drops when taken", 256'(out_valid), 256'd0);
      end

      // R4 lane order with eight different bytes, code 1
      send(3'd1, {8'h40, 8'h01, 8'h7E, 8'h7F, 8'h80, 8'h00, 8'hC0, 8'h38});
      begin
         logic [31:0] exp_l [8];
         exp_l = '{32'h3F80_0000, 32'hC000_0000, 32'h0000_0000, 32'h8000_0000,
                   32'h7FC0_0000, 32'h43E0_0000, 32'h3B00_0000, 32'h4000_0000};
         for (int i = 0; i < 8; i++) begin
            check(out_lanes[i*32 +: 32] == exp_l[i], $sformatf("R4 lane %0d", i),
                  256'(out_lanes[i*32 +: 32]), 256'(exp_l[i]));
         end
      end
      @(negedge clk);

      // R10 mixed lanes in code 3: only the 0x80 lane is NaN
      send(3'd3, {8'h00, 8'h80, 8'h40, 8'h01, 8'h00, 8'h80, 8'h40, 8'h01});
      check(out_lanes == {32'h0, 32'h7FC0_0000, 32'h3F80_0000, 32'h3A80_0000,
                          32'h0, 32'h7FC0_0000, 32'h3F80_0000, 32'h3A80_0000},
            "R10 mixed lanes", out_lanes,
            {32'h0, 32'h7FC0_0000, 32'h3F80_0000, 32'h3A80_0000,
             32'h0, 32'h7FC0_0000, 32'h3F80_0000, 32'h3A80_0000});
      @(negedge clk);

      // R2 backpressure
      out_ready = 1'b0;
      send(3'd0, {8{8'h3C}});
      held = out_lanes;
      check(in_ready == 1'b0, "R2 refuse while full", 256'(in_ready), 256'd0);
      in_fmt   = 3'd1;
      in_word  = {8{8'h38 ^ 8'h08}};   // 0x30 in code 1 = 0.5
      in_valid = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b1 && out_lanes == held, "R2 hold while stalled", out_lanes, held);
      check(in_ready == 1'b0, "R2 still refusing", 256'(in_ready), 256'd0);
      out_ready = 1'b1;
      #1;
      check(in_ready == 1'b1, "R2 ready when taken", 256'(in_ready), 256'd1);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1 && out_lanes == {8{32'h3F00_0000}}, "R2 next word after release",
            out_lanes, {8{32'h3F00_0000}});
      @(negedge clk);
      check(out_valid == 1'b0, "R1 empty after last take", 256'(out_valid), 256'd0);

      // R3 reset while holding data
      out_ready = 1'b0;
      send(3'd2, {8{8'h40}});
      rst_n = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, "R3 reset clears held result",
            256'({out_valid, in_ready}), 256'b01);
      rst_n = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule